// File: doc/BRIEF.md
# Real-Time Clock with Snapshot and Write-Lock Registers

This block keeps calendar time (seconds, minutes, hours, weekday, day of month, month and two-digit year) in a running core that advances once per second. The second is made by counting pulses of a 32.768 kHz time base. That time base arrives as a single-cycle enable, `osc_en`, in the system clock domain. All fields are kept in BCD. Hours run from 00 to 23. The weekday runs from 1 to 7. February has 29 days in every year whose two-digit value is a multiple of four.

Software never reaches the running core directly. It sees a set of holding registers through a small register port, and two control bits decide when those registers and the core exchange values:
- A rising edge on the snapshot bit freezes a coherent copy of the time. If a second boundary falls in the same cycle, it is counted before the copy is taken.
- The lock bit stops the core and lets software write new time fields into the holding registers. Clearing the lock loads those fields into the core and restarts the one-second prescaler.

While neither bit is set, the holding registers track the core.

Top module: `rtc_snapshot_top`

## Requirements
- R1: After reset, the control register reads 0 and the time reads 00:00:00, weekday 01, date 01, month 01, year 00.
- R2: Exactly one second tick occurs per DIV pulses of `osc_en`. Each tick that is not blocked by the lock advances the seconds by one.
- R3: Time fields count in BCD. Seconds wrap from 59 to 00 and carry into the minutes. Minutes wrap from 59 to 00 and carry into the hours. Hours wrap from 23 to 00 and carry into the day.
- R4: On a day carry, the weekday advances, and it wraps from 07 to 01.
- R5: On a day carry, the date wraps to 01 after the last day of the month and advances the month. Months 04, 06, 09 and 11 have 30 days. February has 29 days when the year is a multiple of four and 28 days otherwise. The other months have 31 days. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R6: A write that changes the snapshot bit (control bit 0) from 0 to 1 while the lock bit is 0 copies the core into the holding registers. If a tick is due in that same cycle, it is applied first.
- R7: While the snapshot bit is 1 and the lock bit is 0, the holding registers do not change, although the core keeps counting. Once the snapshot bit is cleared, they again show the live core time.
- R8: Writes to time addresses are ignored while the lock bit (control bit 1) is 0. While the lock bit is 1, they land in the holding registers and read back, and the core does not count.
- R9: Writing the lock bit from 1 to 0 loads the holding registers into the core and clears the prescaler. The next tick therefore comes only after DIV further pulses.
- R10: While both control bits are 0, the holding registers show the core time, including each new tick.
- R11: Reads return data one clock after the address is presented. The address map is: 0 = control ({6'b0, lock, snapshot}), 1 = seconds, 2 = minutes, 3 = hours, 4 = weekday, 5 = date, 6 = month, 7 = year. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One-cycle pulse per period of the 32.768 kHz time base |
| reg_addr | input | AW | Register address for reads and writes |
| reg_we | input | 1 | Write strobe for `reg_wdata` at `reg_addr` |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data, one cycle after the address |

## Verification
A fault in the calendar step shows up at the first tick that reaches the faulty field. From that point the wrong value is visible at the ports, because idle holding registers follow the core. A prescaler that keeps stale state across a commit moves the first tick earlier than DIV pulses, so the bench counts pulses after each commit. A snapshot that copies the core before a pending tick reads back one second old. The bench catches this by raising the snapshot bit in the exact cycle the tick lands, then reading the held seconds.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int NF = 7;          // number of time fields
  localparam int TW = NF * 8;     // packed time width

  // sec occupies the low byte; field k sits at [k*8 +: 8]
  typedef struct packed {
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam rtc_time_t TIME_RESET = '{year: 8'h00, mon: 8'h01, date: 8'h01,
                                       dow: 8'h01, hour: 8'h00, min: 8'h00,
                                       sec: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return {v[7:4], v[3:0] + 4'h1};
  endfunction

  // multiple-of-four test done directly on the two BCD digits
  function automatic logic year_leap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
    return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return year_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_en,
  input  logic clear,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (osc_en) begin
        if (cnt == LAST) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
  import rtc_pkg::*;
(
  input  rtc_time_t cur,
  output rtc_time_t nxt
);
  logic [7:0] last_day;

  always_comb begin
    nxt      = cur;
    last_day = month_last_day(cur.mon, cur.year);
    if (cur.sec != 8'h59) begin
      nxt.sec = bcd_inc(cur.sec);
    end else begin
      nxt.sec = 8'h00;
      if (cur.min != 8'h59) begin
        nxt.min = bcd_inc(cur.min);
      end else begin
        nxt.min = 8'h00;
        if (cur.hour != 8'h23) begin
          nxt.hour = bcd_inc(cur.hour);
        end else begin
          nxt.hour = 8'h00;
          nxt.dow  = (cur.dow == 8'h07) ? 8'h01 : bcd_inc(cur.dow);
          if (cur.date != last_day) begin
            nxt.date = bcd_inc(cur.date);
          end else begin
            nxt.date = 8'h01;
            if (cur.mon != 8'h12) begin
              nxt.mon = bcd_inc(cur.mon);
            end else begin
              nxt.mon  = 8'h01;
              nxt.year = (cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [7:0]    wdata,
  input  logic [TW-1:0] core_d,
  output logic [TW-1:0] hold,
  output logic [7:0]    rdata,
  output logic          snap_bit,
  output logic          lock_bit,
  output logic          commit
);
  localparam logic [TW-1:0] HOLD_RST = TIME_RESET;

  logic ctrl_wr, snap;
  logic [7:0] rd_next;

  assign ctrl_wr = we && (addr == '0);
  assign snap    = ctrl_wr && !snap_bit && !lock_bit && wdata[0];
  assign commit  = ctrl_wr && lock_bit && !wdata[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_bit <= 1'b0;
      lock_bit <= 1'b0;
    end else if (ctrl_wr) begin
      snap_bit <= wdata[0];
      lock_bit <= wdata[1];
    end
  end

  for (genvar k = 0; k < NF; k++) begin : g_field
    logic fld_wr;
    assign fld_wr = we && lock_bit && (addr == AW'(k + 1));
    always_ff @(posedge clk) begin
      if (rst)
        hold[k*8 +: 8] <= HOLD_RST[k*8 +: 8];
      else if (fld_wr)
        hold[k*8 +: 8] <= wdata;
      else if (snap || (!snap_bit && !lock_bit))
        hold[k*8 +: 8] <= core_d[k*8 +: 8];
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr == '0) rd_next = {6'b0, lock_bit, snap_bit};
    for (int k = 0; k < NF; k++)
      if (addr == AW'(k + 1)) rd_next = hold[k*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/rtc_snapshot_top.sv
module rtc_snapshot_top
  import rtc_pkg::*;
#(
  parameter int DIV = 32768,
  parameter int AW  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          osc_en,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata
);
  logic          tick, commit, r_bit, w_lock;
  logic [TW-1:0] hold_v;
  rtc_time_t     core_q, core_step, core_d;

  rtc_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .osc_en(osc_en), .clear(commit), .tick(tick)
  );

  rtc_cal_step u_step (.cur(core_q), .nxt(core_step));

  always_comb begin
    if (commit)             core_d = rtc_time_t'(hold_v);
    else if (tick && !w_lock) core_d = core_step;
    else                    core_d = core_q;
  end

  always_ff @(posedge clk) begin
    if (rst) core_q <= TIME_RESET;
    else     core_q <= core_d;
  end

  rtc_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .core_d(core_d), .hold(hold_v), .rdata(reg_rdata),
    .snap_bit(r_bit), .lock_bit(w_lock), .commit(commit)
  );
endmodule

// File: rtl/rtc_snapshot_chk.sv
module rtc_snapshot_chk
  import rtc_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          commit,
  input logic          r_bit,
  input logic          w_lock,
  input logic [TW-1:0] core,
  input logic [TW-1:0] hold
);
  // a tick lasts one cycle
  assert_tick_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // an unblocked tick always moves the core
  assert_tick_advances_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !w_lock && !commit) |=> core != $past(core));

  // while locked and not committing, the core holds still
  assert_core_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (w_lock && !commit) |=> $stable(core));

  // frozen holding registers under an active snapshot
  assert_hold_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (r_bit && !w_lock) |=> $stable(hold));

  // snapshot copy matches the core it was taken from
  assert_snapshot_copy_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(r_bit) && !w_lock) |-> hold == core);

  // commit loads the holding values
  assert_commit_load_R9: assert property (@(posedge clk) disable iff (rst)
    commit |=> core == $past(hold));
endmodule

bind rtc_snapshot_top rtc_snapshot_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .commit(commit), .r_bit(r_bit),
  .w_lock(w_lock), .core(core_q), .hold(hold_v)
);

// File: tb/sim_rtc_snapshot_top.sv
module sim_rtc_snapshot_top;
  localparam int DIV = 4;
  localparam int AW  = 4;
  localparam int NV  = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          osc_en = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_snapshot_top #(.DIV(DIV), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .osc_en(osc_en), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // {start, expected after one tick}; bytes: year mon date dow hour min sec
  localparam logic [111:0] VEC [NV] = '{
    {56'h23061503123456, 56'h23061503123457},  // R2 plain second
    {56'h23061503090909, 56'h23061503090910},  // R3 BCD digit carry
    {56'h23061503000059, 56'h23061503000100},  // R3 sec wrap
    {56'h23061503005959, 56'h23061503010000},  // R3 min wrap
    {56'h23061503195959, 56'h23061503200000},  // R3 hour digit carry
    {56'h24013107235959, 56'h24020101000000},  // R4 weekday wrap, R5 Jan
    {56'h23022802235959, 56'h23030103000000},  // R5 Feb non-leap
    {56'h24022802235959, 56'h24022903000000},  // R5 Feb leap
    {56'h24022903235959, 56'h24030104000000},  // R5 leap day end
    {56'h21043004235959, 56'h21050105000000},  // R5 30-day month
    {56'h00093001235959, 56'h00100102000000},  // R5 BCD month carry
    {56'h99123105235959, 56'h00010106000000}   // R5 year wrap
  };

  task automatic check(input string tag, input logic [55:0] got, input logic [55:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // tasks start at a negative edge and end at one
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    reg_addr = a;
    @(posedge clk); @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      osc_en = 1'b1;
      @(posedge clk); @(negedge clk);
    end
    osc_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic load_fields(input logic [55:0] t);
    for (int i = 0; i < 7; i++) wr(AW'(i + 1), t[i*8 +: 8]);
  endtask

  task automatic read_time(output logic [55:0] t);
    logic [7:0] b;
    for (int i = 0; i < 7; i++) begin
      rd(AW'(i + 1), b);
      t[i*8 +: 8] = b;
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [55:0] t;
    logic [7:0]  b;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state, R11 map
    rd(0, b);   check("R1 ctrl", {48'b0, b}, 56'h0);
    read_time(t); check("R1 reset time", t, 56'h00010101000000);
    rd(8, b);   check("R11 unmapped address", {48'b0, b}, 56'h0);

    // R2..R5 table
    for (int v = 0; v < NV; v++) begin
      wr(0, 8'h02);
      load_fields(VEC[v][111:56]);
      wr(0, 8'h00);
      pulses(DIV);
      idle(3);
      read_time(t);
      check($sformatf("R2 R3 R4 R5 vector %0d", v), t, VEC[v][55:0]);
    end

    // R8: writes ignored while unlocked
    wr(0, 8'h00);
    load_fields(56'h20010101100000);
    wr(1, 8'h42);
    rd(1, b); check("R8 write ignored unlocked", {48'b0, b}, {48'b0, t[7:0]});

    // R8 locked write visible, R11 ctrl readback
    wr(0, 8'h02);
    rd(0, b); check("R11 ctrl lock bit", {48'b0, b}, 56'h2);
    load_fields(56'h20010101100000);
    rd(1, b); check("R8 locked write readback", {48'b0, b}, 56'h0);
    pulses(2 * DIV + 2);   // leaves prescaler mid-count, core stopped
    read_time(t); check("R8 no counting while locked", t, 56'h20010101100000);

    // R9 commit restarts prescaler
    wr(0, 8'h00);
    pulses(DIV - 1);
    idle(3);
    read_time(t); check("R9 no tick before full second", t, 56'h20010101100000);
    pulses(1);
    idle(3);
    rd(1, b); check("R9 first tick after commit", {48'b0, b}, 56'h01);

    // R6 snapshot raised in the cycle the tick lands
    pulses(DIV);
    wr(0, 8'h01);
    rd(1, b); check("R6 pending tick applied", {48'b0, b}, 56'h02);

    // R7 frozen under snapshot
    pulses(2 * DIV);
    idle(3);
    rd(1, b); check("R7 frozen while snapshot set", {48'b0, b}, 56'h02);
    wr(0, 8'h00);
    idle(1);
    rd(1, b); check("R7 resumes after clear", {48'b0, b}, 56'h04);

    // R10 idle follows each tick
    pulses(DIV);
    idle(3);
    rd(1, b); check("R10 follows core", {48'b0, b}, 56'h05);
    pulses(DIV);
    idle(3);
    read_time(t); check("R10 follows core again", t, 56'h20010101100006);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule